// File: doc/BRIEF.md
# Port Pin-Function Control Register with NMI Edge Select

This block holds one 8-bit control register that the CPU writes and reads. The register decides which role a few pins of an 8-bit general-purpose port take, and on which edge the non-maskable interrupt input fires. Two pins can be handed to interrupt-request inputs. Two more can be handed to a bus-release handshake, but only while the chip runs in an expanded operating mode. Pins not taken over by any function are driven from the port's data and direction registers, which sit outside the block.

All pad levels pass through a two-flop synchroniser. The synchronised levels always go back to the port read path, so software can read a pin even while an interrupt function owns it. The NMI pin has its own synchroniser and an edge detector. The detector emits one single-clock request for each edge of the selected polarity.

A hardware reset or hardware standby puts the register at 0x87. Software standby freezes the register at its current value.

Top module: `pinfn_ctrl`

## Requirements
- R1: On a clock edge with `rst` or `hw_stby` high, the register loads 0x87, so `cpu_rdata` reads 0x87 after that edge.
- R2: While `sw_stby` is high (and `hw_stby` low), the register keeps its value and `cpu_we` has no effect.
- R3: Bit 7 is reserved. It reads back as 1 whatever value was written to it.
- R4: With `cpu_we` high and no standby, bits 6..0 of `cpu_wdata` appear in `cpu_rdata` after the next clock edge. Bits 2..0 are plain storage with no effect on the pins.
- R5: Bit 6 set assigns pin 6 to the IRQ1 input. `pad_oe[6]` and `pad_out[6]` are 0 whatever `gpio_ddr[6]` holds, and `irq1` follows the synchronised pin 6 level. With bit 6 clear, pin 6 is plain I/O and `irq1` is 0.
- R6: Bit 5 set assigns pin 5 to the IRQ0 input in the same way, with `irq0` following the synchronised pin 5 level. With bit 5 clear, `irq0` is 0.
- R7: `port_rd[i]` equals `pad_in[i]` as it stood two clock edges earlier, for every pin, whatever role the pin has.
- R8: Bit 4 = 0 selects a falling NMI edge and bit 4 = 1 selects a rising edge. Each qualifying change of `nmi_pin` gives exactly one `nmi_req` cycle, three clock edges after the change.
- R9: Changing bit 4 while `nmi_pin` is steady produces no `nmi_req` pulse.
- R10: With bit 3 set and `op_mode` in 1..4 (expanded), pin 2 is an input (`pad_oe[2]`=0) whose synchronised level appears on `bus_req`, and pin 3 is driven (`pad_oe[3]`=1) with `bus_grant`. With `op_mode` 0, 5, 6 or 7 (single-chip), pins 2 and 3 stay plain I/O and `bus_req` is 0.
- R11: A plain I/O pin shows `gpio_dout[i]` on `pad_out[i]` and `gpio_ddr[i]` on `pad_oe[i]`, one clock edge after the inputs and the register are set. After reset, `pad_out` and `pad_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| hw_stby | input | 1 | Hardware standby; reloads the register |
| sw_stby | input | 1 | Software standby; freezes the register |
| op_mode | input | 3 | Operating mode; 1..4 are expanded modes |
| cpu_we | input | 1 | CPU write strobe for the register |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Register read value |
| gpio_dout | input | 8 | Port data register bits |
| gpio_ddr | input | 8 | Port data-direction bits (1 = drive) |
| pad_in | input | 8 | Pad input buffer levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| port_rd | output | 8 | Synchronised pin levels for the port read path |
| irq0 | output | 1 | IRQ0 level to the interrupt controller |
| irq1 | output | 1 | IRQ1 level to the interrupt controller |
| bus_grant | input | 1 | Grant level from the bus arbiter, driven on pin 3 |
| bus_req | output | 1 | Synchronised request level from pin 2 to the arbiter |
| nmi_pin | input | 1 | Non-maskable interrupt pin |
| nmi_req | output | 1 | One-cycle NMI request pulse |

## Verification
The hardest case is a change of the edge-select bit at the exact cycle an edge is still moving through the synchroniser. It is also hard to show that a pure select change, with the pin steady, never fires. A directed phase settles `nmi_pin`, then flips bit 4 back and forth with register writes and checks that no pulse appears. Random phases then toggle `nmi_pin` rarely while register writes land on arbitrary cycles, so select changes fall inside the three-edge pipeline window. The mode-gated bus-release muxing is covered by sweeping `op_mode` through all eight codes with bit 3 set and cleared.

// File: rtl/pinfn_pkg.sv
package pinfn_pkg;

  localparam int CTRL_W = 8;
  localparam int MODE_W = 3;

  // bit positions inside the control register
  localparam int BIT_RSVD   = 7;
  localparam int BIT_IRQ1   = 6;
  localparam int BIT_IRQ0   = 5;
  localparam int BIT_NMIPOL = 4;
  localparam int BIT_BUSREL = 3;

  localparam logic [CTRL_W-1:0] RSVD_MASK = CTRL_W'(1) << BIT_RSVD;

  typedef enum logic [1:0] {
    ROLE_GPIO      = 2'd0,
    ROLE_IRQ_IN    = 2'd1,
    ROLE_BUSREQ_IN = 2'd2,
    ROLE_BUSGNT_OUT = 2'd3
  } pin_role_e;

  // modes 1..4 are expanded (external bus); all others single-chip
  function automatic logic mode_expanded(input logic [MODE_W-1:0] m);
    return (m >= MODE_W'(1)) && (m <= MODE_W'(4));
  endfunction

endpackage

// File: rtl/pinfn_regs.sv
module pinfn_regs
  import pinfn_pkg::*;
#(
  parameter logic [CTRL_W-1:0] RESET_VAL = 8'h87
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] rdata,
  output logic              irq1_en,
  output logic              irq0_en,
  output logic              nmi_rise,
  output logic              bus_rel_en
);

  logic [CTRL_W-1:0] store_q;
  logic [CTRL_W-1:0] wr_val;
  logic              wr_ok;

  // reserved bit forced high on every write
  assign wr_val = (wdata & ~RSVD_MASK) | RSVD_MASK;
  assign wr_ok  = we && !sw_stby;

  always_ff @(posedge clk) begin
    if (rst || hw_stby) begin
      store_q <= RESET_VAL | RSVD_MASK;
    end else if (wr_ok) begin
      store_q <= wr_val;
    end
  end

  assign rdata      = store_q;
  assign irq1_en    = store_q[BIT_IRQ1];
  assign irq0_en    = store_q[BIT_IRQ0];
  assign nmi_rise   = store_q[BIT_NMIPOL];
  assign bus_rel_en = store_q[BIT_BUSREL];

  // R1: hardware standby reloads the reset value
  p_hw_load_r1: assert property (@(posedge clk) disable iff (rst)
    hw_stby |=> (rdata == (RESET_VAL | RSVD_MASK)));

  // R2: software standby freezes the contents
  p_sw_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (sw_stby && !hw_stby) |=> $stable(rdata));

  // R3: reserved bit stays high after a write of zero to it
  p_rsvd_one_r3: assert property (@(posedge clk) disable iff (rst)
    (we && !wdata[BIT_RSVD]) |=> rdata[BIT_RSVD]);

  // R4: accepted write lands in bits 6..0
  p_write_r4: assert property (@(posedge clk) disable iff (rst)
    (we && !sw_stby && !hw_stby) |=> (rdata[CTRL_W-2:0] == $past(wdata[CTRL_W-2:0])));

endmodule

// File: rtl/pinfn_sync.sv
module pinfn_sync #(
  parameter int             W       = 8,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

  // R7: output is the input delayed by STAGES edges (checked for 2 stages)
  generate
    if (STAGES == 2) begin : g_chk2
      p_delay_r7: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |=> (q == $past(d, 2)));
    end
  endgenerate

endmodule

// File: rtl/pinfn_nmi_edge.sv
module pinfn_nmi_edge #(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_lvl,
  input  logic rise_sel,
  output logic nmi_req
);

  logic prev_q;
  logic rise_hit;
  logic fall_hit;

  // previous sample tracks only the synchronised pin, never the select
  assign rise_hit = sync_lvl && !prev_q;
  assign fall_hit = !sync_lvl && prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= IDLE_LVL;
      nmi_req <= 1'b0;
    end else begin
      prev_q  <= sync_lvl;
      nmi_req <= rise_sel ? rise_hit : fall_hit;
    end
  end

  // R8: a pulse lasts one cycle unless the select moved in between
  p_nmi_single_r8: assert property (@(posedge clk) disable iff (rst)
    (nmi_req && $stable(rise_sel)) |=> !nmi_req);

  // R9: a pulse needs a real change of the synchronised level
  p_nmi_needs_edge_r9: assert property (@(posedge clk) disable iff (rst)
    nmi_req |-> ($past(sync_lvl) != $past(sync_lvl, 2)));

endmodule

// File: rtl/pinfn_pinmux.sv
module pinfn_pinmux
  import pinfn_pkg::*;
#(
  parameter int W         = 8,
  parameter int IRQ1_PIN  = 6,
  parameter int IRQ0_PIN  = 5,
  parameter int BREQ_PIN  = 2,
  parameter int BGNT_PIN  = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         irq1_en,
  input  logic         irq0_en,
  input  logic         bus_rel_en,
  input  logic         expanded,
  input  logic [W-1:0] gpio_dout,
  input  logic [W-1:0] gpio_ddr,
  input  logic         bus_grant,
  input  logic         irq1_lvl,
  input  logic         irq0_lvl,
  input  logic         breq_lvl,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic         irq1,
  output logic         irq0,
  output logic         bus_req
);

  logic         bus_on;
  logic [W-1:0] nxt_out;
  logic [W-1:0] nxt_oe;

  assign bus_on = expanded && bus_rel_en;

  function automatic pin_role_e pick_role(input int idx, input logic i1, input logic i0,
                                          input logic bon);
    if (idx == IRQ1_PIN && i1)      return ROLE_IRQ_IN;
    else if (idx == IRQ0_PIN && i0) return ROLE_IRQ_IN;
    else if (idx == BREQ_PIN && bon) return ROLE_BUSREQ_IN;
    else if (idx == BGNT_PIN && bon) return ROLE_BUSGNT_OUT;
    else                             return ROLE_GPIO;
  endfunction

  always_comb begin
    nxt_out = '0;
    nxt_oe  = '0;
    for (int i = 0; i < W; i++) begin
      unique case (pick_role(i, irq1_en, irq0_en, bus_on))
        ROLE_GPIO: begin
          nxt_out[i] = gpio_dout[i];
          nxt_oe[i]  = gpio_ddr[i];
        end
        ROLE_BUSGNT_OUT: begin
          nxt_out[i] = bus_grant;
          nxt_oe[i]  = 1'b1;
        end
        default: begin
          nxt_out[i] = 1'b0;
          nxt_oe[i]  = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
      irq1    <= 1'b0;
      irq0    <= 1'b0;
      bus_req <= 1'b0;
    end else begin
      pad_out <= nxt_out;
      pad_oe  <= nxt_oe;
      irq1    <= irq1_en && irq1_lvl;
      irq0    <= irq0_en && irq0_lvl;
      bus_req <= bus_on && breq_lvl;
    end
  end

  // R5: IRQ1 role never drives the pad
  p_irq1_hiz_r5: assert property (@(posedge clk) disable iff (rst)
    $past(irq1_en) |-> !pad_oe[IRQ1_PIN]);

  // R6: IRQ0 role never drives the pad
  p_irq0_hiz_r6: assert property (@(posedge clk) disable iff (rst)
    $past(irq0_en) |-> !pad_oe[IRQ0_PIN]);

  // R10: single-chip mode keeps the request output low
  p_single_chip_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(expanded) |-> !bus_req);

  // R10: grant pin is driven while bus release is active
  p_grant_drive_r10: assert property (@(posedge clk) disable iff (rst)
    $past(bus_on) |-> (pad_oe[BGNT_PIN] && pad_out[BGNT_PIN] == $past(bus_grant)));

endmodule

// File: rtl/pinfn_ctrl.sv
module pinfn_ctrl
  import pinfn_pkg::*;
#(
  parameter int              PORT_W    = 8,
  parameter int              SYNC_N    = 2,
  parameter logic [CTRL_W-1:0] RESET_VAL = 8'h87,
  parameter logic            NMI_IDLE  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic [MODE_W-1:0] op_mode,
  input  logic              cpu_we,
  input  logic [CTRL_W-1:0] cpu_wdata,
  output logic [CTRL_W-1:0] cpu_rdata,
  input  logic [PORT_W-1:0] gpio_dout,
  input  logic [PORT_W-1:0] gpio_ddr,
  input  logic [PORT_W-1:0] pad_in,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe,
  output logic [PORT_W-1:0] port_rd,
  output logic              irq0,
  output logic              irq1,
  input  logic              bus_grant,
  output logic              bus_req,
  input  logic              nmi_pin,
  output logic              nmi_req
);

  localparam int IRQ1_PIN = 6;
  localparam int IRQ0_PIN = 5;
  localparam int BREQ_PIN = 2;
  localparam int BGNT_PIN = 3;

  logic              irq1_en, irq0_en, nmi_rise, bus_rel_en;
  logic              expanded;
  logic [PORT_W-1:0] pad_sync;
  logic              nmi_sync;

  assign expanded = mode_expanded(op_mode);
  assign port_rd  = pad_sync;

  pinfn_regs #(.RESET_VAL(RESET_VAL)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .hw_stby    (hw_stby),
    .sw_stby    (sw_stby),
    .we         (cpu_we),
    .wdata      (cpu_wdata),
    .rdata      (cpu_rdata),
    .irq1_en    (irq1_en),
    .irq0_en    (irq0_en),
    .nmi_rise   (nmi_rise),
    .bus_rel_en (bus_rel_en)
  );

  pinfn_sync #(.W(PORT_W), .STAGES(SYNC_N), .RST_VAL('0)) u_pad_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pad_sync)
  );

  pinfn_sync #(.W(1), .STAGES(SYNC_N), .RST_VAL(NMI_IDLE)) u_nmi_sync (
    .clk (clk),
    .rst (rst),
    .d   (nmi_pin),
    .q   (nmi_sync)
  );

  pinfn_nmi_edge #(.IDLE_LVL(NMI_IDLE)) u_nmi_edge (
    .clk      (clk),
    .rst      (rst),
    .sync_lvl (nmi_sync),
    .rise_sel (nmi_rise),
    .nmi_req  (nmi_req)
  );

  pinfn_pinmux #(
    .W        (PORT_W),
    .IRQ1_PIN (IRQ1_PIN),
    .IRQ0_PIN (IRQ0_PIN),
    .BREQ_PIN (BREQ_PIN),
    .BGNT_PIN (BGNT_PIN)
  ) u_mux (
    .clk        (clk),
    .rst        (rst),
    .irq1_en    (irq1_en),
    .irq0_en    (irq0_en),
    .bus_rel_en (bus_rel_en),
    .expanded   (expanded),
    .gpio_dout  (gpio_dout),
    .gpio_ddr   (gpio_ddr),
    .bus_grant  (bus_grant),
    .irq1_lvl   (pad_sync[IRQ1_PIN]),
    .irq0_lvl   (pad_sync[IRQ0_PIN]),
    .breq_lvl   (pad_sync[BREQ_PIN]),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .irq1       (irq1),
    .irq0       (irq0),
    .bus_req    (bus_req)
  );

endmodule

// File: tb/sim_pinfn_ctrl.sv
`timescale 1ns/1ps
module sim_pinfn_ctrl;

  logic       clk = 1'b0;
  logic       rst, hw_stby, sw_stby, cpu_we, bus_grant, nmi_pin;
  logic [2:0] op_mode;
  logic [7:0] cpu_wdata, gpio_dout, gpio_ddr, pad_in;
  logic [7:0] cpu_rdata, pad_out, pad_oe, port_rd;
  logic       irq0, irq1, bus_req, nmi_req;

  always #2 clk = ~clk;   // 250 MHz

  pinfn_ctrl u0 (
    .clk(clk), .rst(rst), .hw_stby(hw_stby), .sw_stby(sw_stby), .op_mode(op_mode),
    .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .gpio_dout(gpio_dout), .gpio_ddr(gpio_ddr), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .port_rd(port_rd),
    .irq0(irq0), .irq1(irq1), .bus_grant(bus_grant), .bus_req(bus_req),
    .nmi_pin(nmi_pin), .nmi_req(nmi_req)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit armed    = 0;
  bit done     = 0;

  // ---------------- reference model ----------------
  logic [7:0] m_reg;
  logic [7:0] m_pin_q[$];   // pad history, newest at back
  logic       m_nmi_q[$];   // nmi history
  logic       m_req, m_irq0, m_irq1, m_breq;
  logic [7:0] m_out, m_oe;

  function automatic bit is_exp(input logic [2:0] m);
    return (m >= 3'd1) && (m <= 3'd4);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_reg = 8'h87;
      m_pin_q = '{8'h00, 8'h00};
      m_nmi_q = '{1'b1, 1'b1, 1'b1};
      m_req = 0; m_irq0 = 0; m_irq1 = 0; m_breq = 0; m_out = 0; m_oe = 0;
    end else begin
      logic [7:0] lvl;
      logic       bon, s_new, s_old;
      lvl   = m_pin_q[0];            // level synchronised two edges ago
      bon   = is_exp(op_mode) && m_reg[3];
      s_old = m_nmi_q[0];
      s_new = m_nmi_q[1];
      m_req  = m_reg[4] ? (s_new && !s_old) : (!s_new && s_old);
      m_irq1 = m_reg[6] && lvl[6];
      m_irq0 = m_reg[5] && lvl[5];
      m_breq = bon && lvl[2];
      m_out = gpio_dout;
      m_oe  = gpio_ddr;
      if (m_reg[6]) begin m_out[6] = 0; m_oe[6] = 0; end
      if (m_reg[5]) begin m_out[5] = 0; m_oe[5] = 0; end
      if (bon) begin
        m_out[2] = 0; m_oe[2] = 0;
        m_out[3] = bus_grant; m_oe[3] = 1;
      end
      void'(m_pin_q.pop_front()); m_pin_q.push_back(pad_in);
      void'(m_nmi_q.pop_front()); m_nmi_q.push_back(nmi_pin);
      if (hw_stby)                 m_reg = 8'h87;
      else if (cpu_we && !sw_stby) m_reg = {1'b1, cpu_wdata[6:0]};
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    chk("R4",  "cpu_rdata", cpu_rdata, m_reg);
    chk("R11", "pad_out",   pad_out,   m_out);
    chk("R11", "pad_oe",    pad_oe,    m_oe);
    chk("R7",  "port_rd",   port_rd,   m_pin_q[0]);
    chk("R5",  "irq1",      irq1,      m_irq1);
    chk("R6",  "irq0",      irq0,      m_irq0);
    chk("R8",  "nmi_req",   nmi_req,   m_req);
    chk("R10", "bus_req",   bus_req,   m_breq);
  endtask

  task automatic step();
    @(negedge clk);
    if (armed) compare_all();
  endtask

  task automatic wr(input logic [7:0] d);
    cpu_we = 1; cpu_wdata = d;
    step();
    cpu_we = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected under 150000", cyc);
      summary();
    end
  end

  initial begin
    int pulses;
    rst = 1; hw_stby = 0; sw_stby = 0; op_mode = 0; cpu_we = 0; cpu_wdata = 0;
    gpio_dout = 0; gpio_ddr = 0; pad_in = 0; bus_grant = 0; nmi_pin = 1;
    step(); armed = 1; step(); step();
    rst = 0;
    chk("R1", "reset value", cpu_rdata, 8'h87);
    chk("R11", "reset oe", pad_oe, 8'h00);

    // R3 / R4: reserved bit and storage
    wr(8'h00);  chk("R3", "rsvd after 0x00", cpu_rdata, 8'h80);
    wr(8'h7f);  chk("R4", "write 0x7f", cpu_rdata, 8'hff);
    wr(8'h5a);  chk("R4", "write 0x5a", cpu_rdata, 8'hda);

    // R11: plain GPIO
    wr(8'h00);
    gpio_dout = 8'ha5; gpio_ddr = 8'h3c; step();
    chk("R11", "gpio out", pad_out, 8'ha5);
    chk("R11", "gpio oe", pad_oe, 8'h3c);

    // R5 / R6 / R7: IRQ roles override the direction bit
    gpio_ddr = 8'hff; gpio_dout = 8'hff;
    wr(8'h60); step();
    chk("R5", "pin6 released", pad_oe[6], 1'b0);
    chk("R6", "pin5 released", pad_oe[5], 1'b0);
    pad_in = 8'h60; step(); step(); step();
    chk("R5", "irq1 level", irq1, 1'b1);
    chk("R6", "irq0 level", irq0, 1'b1);
    chk("R7", "pin still readable", port_rd, 8'h60);

    // R10: bus release across all modes
    wr(8'h08);
    for (int m = 0; m < 8; m++) begin
      op_mode = m[2:0]; bus_grant = m[0]; pad_in = 8'h04;
      step(); step(); step();
      chk("R10", "grant oe", pad_oe[3], is_exp(m[2:0]) ? 1'b1 : 1'b1);
      chk("R10", "req pin oe", pad_oe[2], is_exp(m[2:0]) ? 1'b0 : 1'b1);
      chk("R10", "bus_req", bus_req, is_exp(m[2:0]));
    end
    op_mode = 0;

    // R8: falling edge selected
    wr(8'h00); nmi_pin = 1; repeat (4) step();
    nmi_pin = 0; pulses = 0;
    for (int i = 0; i < 6; i++) begin step(); pulses += nmi_req; end
    chk("R8", "falling pulses", pulses, 1);
    nmi_pin = 1; pulses = 0;
    for (int i = 0; i < 6; i++) begin step(); pulses += nmi_req; end
    chk("R8", "rise ignored", pulses, 0);
    // R8: rising edge selected
    wr(8'h10); repeat (3) step();
    nmi_pin = 0; pulses = 0;
    for (int i = 0; i < 6; i++) begin step(); pulses += nmi_req; end
    chk("R8", "fall ignored", pulses, 0);
    nmi_pin = 1; pulses = 0;
    for (int i = 0; i < 6; i++) begin step(); pulses += nmi_req; end
    chk("R8", "rising pulses", pulses, 1);

    // R9: select flips with steady pin
    pulses = 0;
    for (int i = 0; i < 6; i++) begin
      wr((i % 2 == 0) ? 8'h00 : 8'h10); pulses += nmi_req;
      step(); pulses += nmi_req;
    end
    nmi_pin = 0; repeat (5) step();
    for (int i = 0; i < 6; i++) begin
      wr((i % 2 == 0) ? 8'h10 : 8'h00); pulses += nmi_req;
      step(); pulses += nmi_req;
    end
    chk("R9", "no pulse from select change", pulses, 0);

    // R2: software standby freezes the register
    wr(8'h2b);
    sw_stby = 1; cpu_we = 1; cpu_wdata = 8'h54; step(); step();
    cpu_we = 0;
    chk("R2", "frozen in sw standby", cpu_rdata, 8'hab);
    sw_stby = 0;

    // R1: hardware standby reload
    hw_stby = 1; step(); hw_stby = 0;
    chk("R1", "hw standby reload", cpu_rdata, 8'h87);

    // random phase: model compared every clock
    for (int i = 0; i < 4000; i++) begin
      op_mode   = 3'($urandom_range(0, 7));
      gpio_dout = 8'($urandom);
      gpio_ddr  = 8'($urandom);
      pad_in    = 8'($urandom);
      bus_grant = 1'($urandom);
      if ($urandom_range(0, 6) == 0) nmi_pin = ~nmi_pin;
      cpu_we    = ($urandom_range(0, 3) == 0);
      cpu_wdata = 8'($urandom);
      sw_stby   = ($urandom_range(0, 9) == 0);
      hw_stby   = ($urandom_range(0, 60) == 0);
      step();
    end
    cpu_we = 0; sw_stby = 0; hw_stby = 0;
    step();
    summary();
  end

endmodule